// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Interface

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host writes a code word serially over a chip-select, serial-clock and data line. It then moves that word into one of two channel registers with a per-channel active-low load strobe. Each channel register drives the code that the analog stage converts. Full scale is 4095 codes at 0.5 mV per code.

All pins are sampled by a fast system clock `clk` and handled as synchronous events. The serial clock rises are found by edge detection. A channel register is transparent while its load strobe is low and holds from the strobe's rising edge. An active-low preset forces both channel registers to zero or to half-scale, and a static select pin picks which. An active-low shutdown pin only raises a status flag and leaves every register alone.

Top module: `dac_serial_front`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, the shift word and both channel codes clear to 0x000 and `shutdown` clears to 0.
- R2: Each `sclk` rise seen with `cs_n` low shifts `sdi` into bit 0 of the shift word and moves the other bits one place towards bit 11. Data enters MSB first, so the word is complete after exactly 12 rises.
- R3: While `cs_n` is high, `sclk` rises leave the shift word unchanged.
- R4: While a channel's load strobe is low and `preset_n` is high, that channel's code equals the shift word one `clk` cycle later. The other channel's code does not change.
- R5: After a channel's load strobe returns high, that channel's code holds the last word it took until the next load or preset.
- R6: A load strobe works the same whether `cs_n` is high or low.
- R7: While `preset_n` is low, both codes become 0x800 if `preset_mid` is 1 and 0x000 if it is 0.
- R8: `preset_n` low takes priority over any load strobe that is low at the same time.
- R9: After `preset_n` returns high, both codes keep the preset value until the next load.
- R10: `shutdown` equals the inverse of `shdn_n` one `clk` cycle later, and `shdn_n` never changes the shift word or either code.
- R11: Shifting while a load strobe is low breaks the protocol, and the bench counts each such shift. A transparent channel still follows every one of those shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Synchronous active-low block reset |
| cs_n | input | 1 | Active-low serial enable |
| sclk | input | 1 | Serial clock; its rise shifts one bit |
| sdi | input | 1 | Serial data, MSB first |
| ld_a_n | input | 1 | Active-low load strobe, channel A |
| ld_b_n | input | 1 | Active-low load strobe, channel B |
| preset_n | input | 1 | Active-low preset of both channels |
| preset_mid | input | 1 | Preset value select: 1 gives 0x800, 0 gives 0x000 |
| shdn_n | input | 1 | Active-low shutdown request |
| code_a | output | 12 | Channel A code |
| code_b | output | 12 | Channel B code |
| shutdown | output | 1 | High while shutdown is requested |

## Verification
The shift word has no port of its own, so it can only be seen through a channel register. The hardest case is a channel that is transparent while bits are still arriving. The bench holds channel B's strobe low and clocks four more bits with chip select low. This is the forbidden pattern, and the bench counts each such shift. It then checks that the code reflects the partially shifted word. Preset-versus-load priority is reached by dropping the preset and a strobe in the same cycle and then releasing them in turn.

// File: rtl/dac_fe_pkg.sv
// Shared constants and types for the dual-channel DAC front end.
// Assumes: nothing beyond IEEE 1800-2017.
package dac_fe_pkg;
    localparam int DEF_CODE_W = 12;
    localparam int N_CH       = 2;
    typedef enum logic [0:0] { CH_A = 1'b0, CH_B = 1'b1 } ch_e;
endpackage

// File: rtl/dac_fe_shift.sv
// Serial input stage: detects rises of the serial clock and shifts data
// in MSB first while chip select is low.
// Assumes: cs_n, sclk and sdi are already synchronous to clk.
module dac_fe_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         sdi,
    output logic [W-1:0] word
);
    logic sclk_q;
    logic rise;

    // Serial-clock rise seen on this clk edge
    always_comb rise = sclk & ~sclk_q;

    // Previous serial clock level, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Shift register: advance one bit per qualified rise
    always_ff @(posedge clk) begin
        if (!rst_n)              word <= '0;
        else if (rise && !cs_n)  word <= {word[W-2:0], sdi};
    end
endmodule

// File: rtl/dac_fe_chan.sv
// One channel register: follows the shift word while its strobe is low,
// holds otherwise, and takes the preset code while preset is low.
// Assumes: ld_n, preset_n and preset_mid are synchronous to clk.
module dac_fe_chan #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preset_n,
    input  logic         preset_mid,
    input  logic         ld_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};
    logic [W-1:0] preset_val;

    // Preset value picked by the select pin
    always_comb preset_val = preset_mid ? HALF : '0;

    // Channel register: preset first, then transparent load, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)         code <= '0;
        else if (!preset_n) code <= preset_val;
        else if (!ld_n)     code <= din;
    end
endmodule

// File: rtl/dac_serial_front.sv
// Top of the dual-channel DAC front end: one serial shift stage feeding
// two channel registers, plus a registered shutdown flag.
// Assumes: all inputs are synchronous to clk (synchronisers sit outside).
module dac_serial_front #(
    parameter int CODE_W = dac_fe_pkg::DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              ld_a_n,
    input  logic              ld_b_n,
    input  logic              preset_n,
    input  logic              preset_mid,
    input  logic              shdn_n,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              shutdown
);
    import dac_fe_pkg::*;

    logic [CODE_W-1:0] shift_word;
    logic [N_CH-1:0]   ld_n_vec;
    logic [CODE_W-1:0] codes [N_CH];

    // Gather strobes into a vector indexed by channel
    always_comb begin
        ld_n_vec[CH_A] = ld_a_n;
        ld_n_vec[CH_B] = ld_b_n;
    end

    dac_fe_shift #(.W(CODE_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .sdi   (sdi),
        .word  (shift_word)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        dac_fe_chan #(.W(CODE_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .preset_n   (preset_n),
            .preset_mid (preset_mid),
            .ld_n       (ld_n_vec[c]),
            .din        (shift_word),
            .code       (codes[c])
        );
    end

    // Drive the per-channel output ports
    always_comb begin
        code_a = codes[CH_A];
        code_b = codes[CH_B];
    end

    // Shutdown flag register
    always_ff @(posedge clk) begin
        if (!rst_n) shutdown <= 1'b0;
        else        shutdown <= ~shdn_n;
    end
endmodule

// File: rtl/dac_serial_front_chk.sv
// Property checker for dac_serial_front, attached by bind below.
module dac_serial_front_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         ld_a_n,
    input logic         ld_b_n,
    input logic         preset_n,
    input logic         preset_mid,
    input logic         shdn_n,
    input logic [W-1:0] shift_word,
    input logic [W-1:0] code_a,
    input logic [W-1:0] code_b,
    input logic         shutdown
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    p_cs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(rst_n)) |=> $stable(shift_word));

    p_follow_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && !ld_a_n) |=> (code_a == $past(shift_word)));

    p_follow_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && !ld_b_n) |=> (code_b == $past(shift_word)));

    p_hold_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && ld_a_n) |=> $stable(code_a));

    p_hold_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && ld_b_n) |=> $stable(code_b));

    p_preset_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_n && preset_mid) |=> (code_a == HALF && code_b == HALF));

    p_preset_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_n && !preset_mid) |=> (code_a == '0 && code_b == '0));

    p_shdn_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> shutdown);

    p_shdn_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_n |=> !shutdown);
endmodule

bind dac_serial_front dac_serial_front_chk #(.W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .ld_a_n     (ld_a_n),
    .ld_b_n     (ld_b_n),
    .preset_n   (preset_n),
    .preset_mid (preset_mid),
    .shdn_n     (shdn_n),
    .shift_word (shift_word),
    .code_a     (code_a),
    .code_b     (code_b),
    .shutdown   (shutdown)
);

// File: tb/dac_serial_front_bench.sv
module dac_serial_front_bench;
    localparam int CLK_P = 10;
    localparam int W     = 12;
    localparam int NV    = 8;
    // {channel, word}: channel 0 = A, 1 = B
    localparam logic [W:0] VEC [NV] = '{13'h0123, 13'h1FFF, 13'h0800, 13'h17FF,
                                        13'h0FFF, 13'h1000, 13'h0A5A, 13'h15A5};

    logic clk = 1'b0;
    logic rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic ld_a_n = 1'b1, ld_b_n = 1'b1, preset_n = 1'b1, preset_mid = 1'b0, shdn_n = 1'b1;
    logic [W-1:0] code_a, code_b;
    logic shutdown;

    int checks = 0, errors = 0, viol = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_a = '0, exp_b = '0;

    always #(CLK_P/2) clk = ~clk;

    dac_serial_front u_dac_serial_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .preset_n(preset_n),
        .preset_mid(preset_mid), .shdn_n(shdn_n),
        .code_a(code_a), .code_b(code_b), .shutdown(shutdown)
    );

    // R11: protocol monitor for shifts made while a strobe is low
    always @(posedge sclk)
        if (!cs_n && (!ld_a_n || !ld_b_n)) viol++;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        sdi = b; tick(2);
        sclk = 1'b1; tick(2);
        sclk = 1'b0; tick(2);
    endtask

    task automatic send_word(logic [W-1:0] w);
        for (int i = W-1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse(logic ch);
        if (ch) ld_b_n = 1'b0; else ld_a_n = 1'b0;
        tick(3);
        ld_a_n = 1'b1; ld_b_n = 1'b1;
        tick(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        tick(4);
        // R1: reset state
        check("R1 code_a", code_a, '0);
        check("R1 code_b", code_b, '0);
        check("R1 shutdown", {11'b0, shutdown}, '0);
        rst_n = 1'b1; tick(2);

        // R2 R4 R5: vector walk, shift a word then load one channel
        for (int v = 0; v < NV; v++) begin
            cs_n = 1'b0;
            send_word(VEC[v][W-1:0]);
            cs_n = 1'b1; tick(1);
            pulse(VEC[v][W]);
            if (VEC[v][W]) exp_b = VEC[v][W-1:0]; else exp_a = VEC[v][W-1:0];
            check("R2/R4 loaded code_a", code_a, exp_a);
            check("R5 other code_b", code_b, exp_b);
        end

        // R3: cs_n high, serial clocks must not shift
        cs_n = 1'b1;
        send_word(12'h3C3);
        pulse(1'b0);
        check("R3 shift held under cs_n high", code_a, 12'h5A5);

        // R6: load with cs_n high
        cs_n = 1'b0; send_word(12'h6D2); cs_n = 1'b1; tick(1);
        pulse(1'b1);
        check("R6 load with cs_n high", code_b, 12'h6D2);
        check("R5 code_a untouched", code_a, 12'h5A5);

        // R11: transparent channel follows shifts made during a low strobe
        ld_b_n = 1'b0; tick(2);
        cs_n = 1'b0;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        cs_n = 1'b1; tick(2);
        check("R11 transparent follows shifts", code_b, 12'hD2B);
        check("R11 violations counted", viol[W-1:0], 12'd4);
        ld_b_n = 1'b1; tick(3);
        check("R5 hold after strobe rise", code_b, 12'hD2B);

        // R7 R8: preset to half-scale with strobe low at the same time
        preset_mid = 1'b1; preset_n = 1'b0; ld_a_n = 1'b0; tick(3);
        check("R8 preset beats load a", code_a, 12'h800);
        check("R7 half-scale b", code_b, 12'h800);
        ld_a_n = 1'b1; tick(1);
        preset_n = 1'b1; tick(3);
        check("R9 holds after release a", code_a, 12'h800);
        check("R9 holds after release b", code_b, 12'h800);
        pulse(1'b0);
        check("R9 next load replaces preset", code_a, 12'hD2B);

        // R7: preset to zero
        preset_mid = 1'b0; preset_n = 1'b0; tick(3);
        preset_n = 1'b1; tick(2);
        check("R7 zero a", code_a, 12'h000);
        check("R7 zero b", code_b, 12'h000);

        // R10: shutdown flag only
        shdn_n = 1'b0; tick(2);
        check("R10 shutdown on", {11'b0, shutdown}, 12'd1);
        check("R10 code_a unchanged", code_a, 12'h000);
        shdn_n = 1'b1; tick(2);
        check("R10 shutdown off", {11'b0, shutdown}, 12'd0);
        pulse(1'b1);
        check("R10 shift word unchanged", code_b, 12'hD2B);

        finish_run();
    end
endmodule